// File: doc/BRIEF.md
# Peripheral Event Routing Matrix

This block is a small crossbar that carries single-cycle event pulses from peripherals to other peripherals without passing through the processor, its interrupt logic or the data bus. Peripherals that produce events feed it either one-cycle pulses (timer compare match, timer overflow, ADC conversion complete, ADC window compare, real-time counter overflow) or level signals (I/O pin state, analog comparator output). Level inputs are turned into one pulse per change. Each of several parallel channels picks one source through a select code. Each consumer of events ("user") picks one channel through its own select code and receives a registered one-cycle action strobe. Typical users are conversion starts, capture triggers, timer clock inputs, DMA starts and pin output changes.

Every path from a source to a user holds exactly two register stages: one at the channel and one at the user. All channels run at the same time, and one channel may feed any number of users. Software can inject an event into any channel with a one-cycle strobe bit. One user slot is wired to a fault latch. When its channel fires, the latch forces the PWM output pins to a safe level until the latch is explicitly cleared. The select codes and strobes come in as plain configuration inputs, so the block can sit behind any register file.

Top module: `evr_matrix`

## Requirements
- R1: While reset is asserted and directly after it, every user strobe and `fault_active` are 0, and `pwm_out` equals `pwm_in`.
- R2: A channel source code c in 1..N_PULSE selects `pulse_src[c-1]`. A pulse on that source present before clock edge A produces a one-cycle strobe on every user that selects the channel, visible after edge A+1 and gone after edge A+2. The strobe is not visible after edge A.
- R3: Codes N_PULSE+1..N_PULSE+N_LEVEL select `level_src[c-N_PULSE-1]`. Every change of that level, rising or falling, produces exactly one event with the R2 timing. A level that is held steady produces none.
- R4: Source code 0, and any code above N_PULSE+N_LEVEL, turns the channel off: no source event reaches its users.
- R5: A user channel-select value v in 1..N_CH connects the user to channel v-1. Value 0, and any value above N_CH, disconnects the user, so its strobe stays 0.
- R6: Bit k of `sw_strobe` injects an event into channel k with the R2 timing. The injected event is ORed with the selected hardware source, so an event on both at once gives a single strobe.
- R7: All channels carry events in the same cycle independently of each other, and one channel drives every user that selects it.
- R8: An event delivered to user FAULT_USER sets `fault_active` after the same edge that raises that user's strobe. While `fault_active` is 1, `pwm_out` equals PWM_SAFE (all zeros by default). The latch stays set until `fault_clear` is sampled high in a cycle with no new fault event. A fault event wins over a simultaneous clear.
- R9: A new source code is used from the next clock edge. An event that has already been captured in a channel register still reaches its users after the channel's code is changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_src | input | N_PULSE | One-cycle event pulses from peripherals |
| level_src | input | N_LEVEL | Level signals from pins and comparators; each change is an event |
| chan_src_sel | input | N_CH*SRC_SEL_W | Source code for each channel; channel k uses bits [k*SRC_SEL_W +: SRC_SEL_W] |
| sw_strobe | input | N_CH | Software event injection, one bit per channel |
| user_chan_sel | input | N_USER*USR_SEL_W | Channel select for each user; user u uses bits [u*USR_SEL_W +: USR_SEL_W] |
| fault_clear | input | 1 | Clears the PWM fault latch |
| pwm_in | input | N_PWM | PWM waveforms from the timer |
| user_act | output | N_USER | One-cycle action strobes to the users |
| pwm_out | output | N_PWM | PWM pins, forced to the safe level while the fault latch is set |
| fault_active | output | 1 | PWM fault latch state |

## Verification
Assertions check on every cycle the following: channels that are switched off or carry no event stay quiet; a software strobe always loads its channel; disconnected users never strobe; each level change yields the matching pulse; the fault latch follows its fault-user strobe, stays set without a clear, and always lets a new fault win over a clear. The exact two-edge latency from a source to a user, the mapping of every source code and user select value (including the out-of-range values), fan-out and parallel channels, and in-flight delivery across a change of select code can only be shown by the bench's sweeps. The bench compares these sweeps against an arithmetic model of the selection codes.

// File: rtl/evr_pkg.sv
package evr_pkg;
   // Default field widths of the configuration inputs
   localparam int SRC_SEL_W_DEF = 8;
   localparam int USR_SEL_W_DEF = 4;

   // True when a select value names an existing entry (1-based, 0 = off)
   function automatic logic code_in_range(input int unsigned code, input int unsigned count);
      return (code != 0) && (code <= count);
   endfunction
endpackage

// File: rtl/evr_edge_det.sv
module evr_edge_det #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   output logic [W-1:0] pulse
);
   logic [W-1:0] lvl_q;
   logic         primed;

   initial assert (W >= 1) else $error("evr_edge_det: W must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         primed <= 1'b0;
      end else begin
         lvl_q  <= level;
         primed <= 1'b1;
      end
   end

   // The first cycle after reset only loads the history, so no false change appears
   assign pulse = primed ? (level ^ lvl_q) : '0;

   // R3: each sampled change of a level, and only a change, gives a pulse
   a_r3_change_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (pulse == (level ^ $past(level))));
endmodule

// File: rtl/evr_channel.sv
module evr_channel #(
   parameter int N_SRC = 12,
   parameter int SEL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_vec,
   input  logic [SEL_W-1:0] sel,
   input  logic             sw,
   output logic             chan_q
);
   import evr_pkg::*;

   logic hit;

   initial assert (N_SRC < (1 << SEL_W))
      else $error("evr_channel: source codes do not fit in SEL_W bits");

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i + 1)) hit = src_vec[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chan_q <= 1'b0;
      else        chan_q <= hit | sw;
   end

   // R6: a software strobe always loads an event into the channel
   a_r6_sw_loads: assert property (@(posedge clk) disable iff (!rst_n)
      sw |=> chan_q);

   // R4: an off or out-of-range code passes nothing but the software strobe
   a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw && !code_in_range(int'(sel), N_SRC)) |=> !chan_q);
endmodule

// File: rtl/evr_user.sv
module evr_user #(
   parameter int N_CH  = 8,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CH-1:0]  chan_vec,
   input  logic [SEL_W-1:0] sel,
   output logic             hit,
   output logic             act_q
);
   import evr_pkg::*;

   initial assert (N_CH < (1 << SEL_W))
      else $error("evr_user: channel numbers do not fit in SEL_W bits");

   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < N_CH; k++) begin
         if (sel == SEL_W'(k + 1)) hit = chan_vec[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= hit;
   end

   // R5: a disconnected user never strobes
   a_r5_user_off: assert property (@(posedge clk) disable iff (!rst_n)
      !code_in_range(int'(sel), N_CH) |=> !act_q);
endmodule

// File: rtl/evr_fault_latch.sv
module evr_fault_latch #(
   parameter int               N_PWM = 4,
   parameter logic [N_PWM-1:0] SAFE  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic             clr,
   input  logic [N_PWM-1:0] pwm_in,
   output logic [N_PWM-1:0] pwm_out,
   output logic             active
);
   initial assert (N_PWM >= 1) else $error("evr_fault_latch: N_PWM must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   active <= 1'b0;
      else if (set) active <= 1'b1;
      else if (clr) active <= 1'b0;
   end

   assign pwm_out = active ? SAFE : pwm_in;

   // R8: the latch holds without a clear
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !clr) |=> active);

   // R8: a new fault wins over a simultaneous clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set && clr) |=> active);
endmodule

// File: rtl/evr_matrix.sv
module evr_matrix #(
   parameter int               N_CH       = 8,
   parameter int               N_PULSE    = 8,
   parameter int               N_LEVEL    = 4,
   parameter int               N_USER     = 8,
   parameter int               N_PWM      = 4,
   parameter int               SRC_SEL_W  = evr_pkg::SRC_SEL_W_DEF,
   parameter int               USR_SEL_W  = evr_pkg::USR_SEL_W_DEF,
   parameter int               FAULT_USER = N_USER - 1,
   parameter logic [N_PWM-1:0] PWM_SAFE   = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PULSE-1:0]          pulse_src,
   input  logic [N_LEVEL-1:0]          level_src,
   input  logic [N_CH*SRC_SEL_W-1:0]   chan_src_sel,
   input  logic [N_CH-1:0]             sw_strobe,
   input  logic [N_USER*USR_SEL_W-1:0] user_chan_sel,
   input  logic                        fault_clear,
   input  logic [N_PWM-1:0]            pwm_in,
   output logic [N_USER-1:0]           user_act,
   output logic [N_PWM-1:0]            pwm_out,
   output logic                        fault_active
);
   localparam int N_SRC = N_PULSE + N_LEVEL;

   initial begin
      assert (N_CH >= 1 && N_USER >= 1 && N_PULSE >= 1 && N_LEVEL >= 1)
         else $error("evr_matrix: every count must be at least 1");
      assert (FAULT_USER >= 0 && FAULT_USER < N_USER)
         else $error("evr_matrix: FAULT_USER out of range");
   end

   logic [N_LEVEL-1:0] level_evt;
   logic [N_SRC-1:0]   src_all;
   logic [N_CH-1:0]    chan_q;
   logic [N_USER-1:0]  user_hit;

   evr_edge_det #(.W(N_LEVEL)) i_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (level_src),
      .pulse (level_evt)
   );

   // Source code c selects src_all[c-1]: pulse sources first, then level changes
   assign src_all = {level_evt, pulse_src};

   for (genvar k = 0; k < N_CH; k++) begin : g_chan
      evr_channel #(.N_SRC(N_SRC), .SEL_W(SRC_SEL_W)) i_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_vec (src_all),
         .sel     (chan_src_sel[k*SRC_SEL_W +: SRC_SEL_W]),
         .sw      (sw_strobe[k]),
         .chan_q  (chan_q[k])
      );
   end

   for (genvar u = 0; u < N_USER; u++) begin : g_user
      evr_user #(.N_CH(N_CH), .SEL_W(USR_SEL_W)) i_user (
         .clk      (clk),
         .rst_n    (rst_n),
         .chan_vec (chan_q),
         .sel      (user_chan_sel[u*USR_SEL_W +: USR_SEL_W]),
         .hit      (user_hit[u]),
         .act_q    (user_act[u])
      );
   end

   evr_fault_latch #(.N_PWM(N_PWM), .SAFE(PWM_SAFE)) i_fault (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (user_hit[FAULT_USER]),
      .clr     (fault_clear),
      .pwm_in  (pwm_in),
      .pwm_out (pwm_out),
      .active  (fault_active)
   );

   // R8: a strobe on the fault user always comes with the latch set
   a_r8_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
      user_act[FAULT_USER] |-> fault_active);

   // R8: the safe level is on the pins whenever the latch is set
   a_r8_safe_pins: assert property (@(posedge clk) disable iff (!rst_n)
      fault_active |-> (pwm_out == PWM_SAFE));
endmodule

// File: tb/test_evr_matrix.sv
`timescale 1ns/1ps
module test_evr_matrix;
   localparam int NC = 8, NP = 8, NL = 4, NU = 8, NW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pulse_src = '0;
   logic [NL-1:0] level_src = '0;
   logic [NC*8-1:0] chan_src_sel;
   logic [NC-1:0] sw_strobe = '0;
   logic [NU*4-1:0] user_chan_sel;
   logic          fault_clear = 1'b0;
   logic [NW-1:0] pwm_in = 4'b1010;
   logic [NU-1:0] user_act;
   logic [NW-1:0] pwm_out;
   logic          fault_active;

   logic [7:0] csel [NC];
   logic [3:0] usel [NU];
   int n_chk = 0, n_fail = 0, cyc = 0;
   logic fmodel = 1'b0;

   always #4 clk = ~clk;

   always_comb begin
      for (int c = 0; c < NC; c++) chan_src_sel[c*8 +: 8] = csel[c];
      for (int u = 0; u < NU; u++) user_chan_sel[u*4 +: 4] = usel[u];
   end

   evr_matrix i_evr_matrix (
      .clk(clk), .rst_n(rst_n), .pulse_src(pulse_src), .level_src(level_src),
      .chan_src_sel(chan_src_sel), .sw_strobe(sw_strobe), .user_chan_sel(user_chan_sel),
      .fault_clear(fault_clear), .pwm_in(pwm_in), .user_act(user_act),
      .pwm_out(pwm_out), .fault_active(fault_active)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 200000) begin
         n_fail++;
         $display("FAIL watchdog: actual cycle %0d expected below 200000", cyc);
         report();
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Model of the routing codes written from R2..R7
   function automatic logic [NU-1:0] model(input logic [NP-1:0] pm, input logic [NL-1:0] lm,
                                            input logic [NC-1:0] sw);
      logic [NC-1:0] ch;
      logic [NU-1:0] r;
      for (int c = 0; c < NC; c++) begin
         int code = int'(csel[c]);
         ch[c] = sw[c];
         if (code >= 1 && code <= NP) ch[c] = ch[c] | pm[code-1];
         if (code > NP && code <= NP + NL) ch[c] = ch[c] | lm[code-NP-1];
      end
      for (int u = 0; u < NU; u++) begin
         int v = int'(usel[u]);
         r[u] = (v >= 1 && v <= NC) ? ch[v-1] : 1'b0;
      end
      return r;
   endfunction

   task automatic clear_fault_if_set();
      if (fmodel) begin
         @(negedge clk); fault_clear = 1'b1;
         @(negedge clk); fault_clear = 1'b0; fmodel = 1'b0;
         chk("R8 clear", 32'(fault_active), 32'd0);
         chk("R8 pins released", 32'(pwm_out), 32'(pwm_in));
      end
   endtask

   task automatic fire(input logic [NP-1:0] pm, input logic [NL-1:0] lm,
                       input logic [NC-1:0] sw, input string req);
      logic [NU-1:0] e;
      @(negedge clk);
      e = model(pm, lm, sw);
      pulse_src = pm; level_src = level_src ^ lm; sw_strobe = sw;
      @(negedge clk);                       // after edge A
      pulse_src = '0; sw_strobe = '0;
      chk({req, " not before two edges"}, 32'(user_act), 32'd0);
      @(negedge clk);                       // after edge A+1
      chk(req, 32'(user_act), 32'(e));
      if (e[NU-1]) fmodel = 1'b1;
      chk("R8 latch", 32'(fault_active), 32'(fmodel));
      chk("R8 pins", 32'(pwm_out), fmodel ? 32'd0 : 32'(pwm_in));
      @(negedge clk);                       // after edge A+2
      chk({req, " one cycle"}, 32'(user_act), 32'd0);
      clear_fault_if_set();
   endtask

   initial begin
      for (int c = 0; c < NC; c++) csel[c] = '0;
      for (int u = 0; u < NU; u++) usel[u] = '0;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 act", 32'(user_act), 32'd0);
      chk("R1 fault", 32'(fault_active), 32'd0);
      chk("R1 pwm", 32'(pwm_out), 32'(pwm_in));
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 act after reset", 32'(user_act), 32'd0);

      // R2, R3, R4: every source code on every channel against every source
      for (int u = 0; u < NU; u++) usel[u] = 4'(u + 1);
      for (int c = 0; c < NC; c++) begin
         for (int code = 0; code <= NP + NL + 2; code++) begin
            for (int k = 0; k < NC; k++) csel[k] = '0;
            csel[c] = 8'(code);
            for (int s = 0; s < NP + NL; s++) begin
               string tag;
               if (code == 0 || code > NP + NL) tag = "R4";
               else if (s < NP) tag = "R2";
               else tag = "R3";
               if (s < NP) fire(NP'(1) << s, '0, '0, tag);
               else        fire('0, NL'(1) << (s - NP), '0, tag);
            end
         end
      end
      csel[0] = 8'(NP + 1);
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk("R3 steady level", 32'(user_act), 32'd0);

      // R5: every user select value
      for (int c = 0; c < NC; c++) csel[c] = 8'(c + 1);
      for (int u = 0; u < NU; u++) begin
         for (int k = 0; k < NU; k++) usel[k] = '0;
         for (int v = 0; v < 16; v++) begin
            usel[u] = 4'(v);
            for (int s = 0; s < NP; s++) fire(NP'(1) << s, '0, '0, "R5");
         end
      end

      // R6: software strobes, alone and together with a hardware event
      for (int c = 0; c < NC; c++) csel[c] = '0;
      for (int u = 0; u < NU; u++) usel[u] = 4'(u + 1);
      for (int m = 0; m < 256; m++) fire('0, '0, 8'(m), "R6");
      csel[0] = 8'd1;
      fire(8'h01, '0, 8'h01, "R6 or");

      // R7: all channels at once, and fan-out of one channel
      for (int c = 0; c < NC; c++) csel[c] = (c < 4) ? 8'(c + 1) : 8'(NP + c - 3);
      fire(8'h0F, 4'hF, '0, "R7 parallel");
      fire(8'h05, 4'hA, '0, "R7 parallel mix");
      for (int u = 0; u < NU; u++) usel[u] = 4'd3;
      fire(8'h04, '0, '0, "R7 fanout");

      // R9: captured event survives a code change; new code acts at once
      for (int u = 0; u < NU; u++) usel[u] = '0;
      usel[0] = 4'd1;
      csel[0] = 8'd1;
      @(negedge clk); pulse_src = 8'h01;
      @(negedge clk); pulse_src = '0; csel[0] = 8'd0;
      @(negedge clk);
      chk("R9 in-flight", 32'(user_act), 32'h01);
      @(negedge clk); csel[0] = 8'd2; pulse_src = 8'h02;
      @(negedge clk); pulse_src = '0;
      @(negedge clk);
      chk("R9 new code", 32'(user_act), 32'h01);

      // R8: set wins over clear, then sticky, then clear
      usel[0] = 4'd0; usel[NU-1] = 4'd1; csel[0] = 8'd1;
      @(negedge clk); pulse_src = 8'h01; fault_clear = 1'b1;
      @(negedge clk); pulse_src = '0;
      @(negedge clk);
      chk("R8 set wins", 32'(fault_active), 32'd1);
      chk("R8 safe pins", 32'(pwm_out), 32'd0);
      fault_clear = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 sticky", 32'(fault_active), 32'd1);
      pwm_in = 4'b0110;
      @(negedge clk);
      chk("R8 pins hold safe", 32'(pwm_out), 32'd0);
      fmodel = 1'b1;
      clear_fault_if_set();

      report();
   end
endmodule